// File: doc/BRIEF.md
# Miss-path address translation unit

This unit turns a virtual address into a physical one, and it is used only after a request has already missed in a virtually tagged cache. The missed request carries a virtual address, a command and a requester id. It passes through three pipeline stages:

- The first stage captures the request and reads the selected set of a two-way set-associative translation array.
- The second stage compares both ways against the upper address bits.
- The third stage builds the rewritten request.

The rewritten request keeps its command and id and carries a physical address made from the page frame number of the matching entry and the untouched 12-bit page offset. When no way matches, no request leaves the unit. Instead, a one-cycle exception flag reports the faulting virtual address and the id.

A new request can enter on every cycle. A valid/ready handshake on the output stalls all three stages together. A separate write port loads entries. The write port places each entry by a fixed rule:

- An entry with the same page number is overwritten in place.
- Otherwise an empty way is filled.
- Otherwise the way named by the per-set pseudo-LRU bit is replaced.

Top module: `vpage_xlate`

## Requirements
- R1: After reset, outValid and excValid are 0, reqReady is 1, and every way of every set is empty, so any lookup raises an exception.
- R2: On a hit, outPaddr equals {ppn of the matching entry, reqVaddr[11:0]}. outCmd and outId equal the request's command and id.
- R3: A request accepted at clock edge t (reqValid and reqReady both high) produces its result from edge t+3 when the output is not stalled. Back-to-back requests are accepted on consecutive cycles.
- R4: On a miss, outValid stays 0. excValid is high for exactly one cycle, at the time the output would have appeared, with excVaddr equal to the request's virtual address and excId equal to its id. outValid and excValid are never high together.
- R5: While outValid is 1 and outReady is 0, outValid, outPaddr, outCmd and outId hold their values. Results leave in acceptance order, with none lost or duplicated.
- R6: The set index is vaddr[16:12] and the compared tag is vaddr[31:17]. An entry hits only if it is valid, has that index and has an equal tag.
- R7: A write of page number wrVpn (index wrVpn[4:0], tag wrVpn[19:5]) with frame wrPpn goes to the way already holding that page number. Failing that, it goes to empty way 0, then to empty way 1, then to the pseudo-LRU victim. It is visible to requests accepted on later edges.
- R8: Each set keeps one pseudo-LRU bit naming the next victim way. A hit in way w, or a write into way w, sets it to the other way. The bit resets to way 0.
- R9: reqReady equals (not outValid) or outReady. An exception slot never stalls the pipeline.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Missed request present |
| reqReady | output | 1 | Pipeline accepts a request this cycle |
| reqVaddr | input | 32 | Virtual address of the request |
| reqCmd | input | 4 | Request command, passed through |
| reqId | input | 6 | Requester id, passed through |
| outValid | output | 1 | Translated request present |
| outReady | input | 1 | Downstream accepts the translated request |
| outPaddr | output | 32 | Physical address |
| outCmd | output | 4 | Command of the translated request |
| outId | output | 6 | Id of the translated request |
| excValid | output | 1 | One-cycle translation-miss exception |
| excVaddr | output | 32 | Faulting virtual address |
| excId | output | 6 | Id of the faulting request |
| wrEn | input | 1 | Load an entry |
| wrVpn | input | 20 | Virtual page number of the entry |
| wrPpn | input | 20 | Physical frame number of the entry |

## Verification
A wrong way choice or a corrupted tag shows up as a wrong frame number or a spurious exception on the very next lookup of that page, three edges after it is accepted. A broken pseudo-LRU bit stays hidden until the following eviction in that set. That eviction then drops the page that was just used, so the bench targets it with a hit-then-write sequence followed by lookups of all three pages. Stage-valid or stall faults show up immediately as results that are early, late, duplicated, or changed while held under back-pressure.

// File: rtl/vpx_pkg.sv
package vpx_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic advance;   // all stages move one step
    logic hitUpd;    // stage-2 hit updates the replacement bit
  } vpxStrb_t;
endpackage

// File: rtl/vpx_ways.sv
module vpx_ways #(
  parameter int SETS   = 32,
  parameter int IDX_W  = 5,
  parameter int ETAG_W = 15,
  parameter int PPN_W  = 20
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [IDX_W-1:0]       rdIdx,
  output logic [1:0][ETAG_W-1:0] rdTag,
  output logic [1:0][PPN_W-1:0]  rdPpn,
  output logic [1:0]             rdVld,
  input  logic                   wrEn,
  input  logic [IDX_W-1:0]       wrIdx,
  input  logic [ETAG_W-1:0]      wrTag,
  input  logic [PPN_W-1:0]       wrPpn,
  input  logic                   hitUpd,
  input  logic [IDX_W-1:0]       hitIdx,
  input  logic                   hitWay
);
  logic [SETS-1:0] plru;
  logic [1:0]      wrMatch;
  logic [1:0]      wrHasV;
  logic            victim;

  for (genvar w = 0; w < 2; w++) begin : gWay
    localparam logic WAY = 1'(w);
    logic [ETAG_W-1:0] tagMem [SETS];
    logic [PPN_W-1:0]  ppnMem [SETS];
    logic [SETS-1:0]   vld;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) vld <= '0;
      else if (wrEn && victim == WAY) vld[wrIdx] <= 1'b1;
    end

    always_ff @(posedge clk) begin
      if (wrEn && victim == WAY) begin
        tagMem[wrIdx] <= wrTag;
        ppnMem[wrIdx] <= wrPpn;
      end
    end

    assign rdTag[w]   = tagMem[rdIdx];
    assign rdPpn[w]   = ppnMem[rdIdx];
    assign rdVld[w]   = vld[rdIdx];
    assign wrHasV[w]  = vld[wrIdx];
    assign wrMatch[w] = vld[wrIdx] && (tagMem[wrIdx] == wrTag);
  end

  always_comb begin
    if (wrMatch[0])      victim = 1'b0;
    else if (wrMatch[1]) victim = 1'b1;
    else if (!wrHasV[0]) victim = 1'b0;
    else if (!wrHasV[1]) victim = 1'b1;
    else                 victim = plru[wrIdx];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) plru <= '0;
    else begin
      if (wrEn) plru[wrIdx] <= ~victim;
      if (hitUpd && !(wrEn && wrIdx == hitIdx)) plru[hitIdx] <= ~hitWay;
    end
  end

  // R7
  write_lands_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> ((gWay[0].vld[$past(wrIdx)] && gWay[0].tagMem[$past(wrIdx)] == $past(wrTag)) ||
              (gWay[1].vld[$past(wrIdx)] && gWay[1].tagMem[$past(wrIdx)] == $past(wrTag))));

  // R7
  no_dup_page_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(wrMatch[0] && wrMatch[1]));

  // R8
  plru_after_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> plru[$past(wrIdx)] != $past(victim));
endmodule

// File: rtl/vpx_dpath.sv
module vpx_dpath import vpx_pkg::*; #(
  parameter int VA_W      = 32,
  parameter int PA_W      = 32,
  parameter int PAGE_BITS = 12,
  parameter int SETS      = 32,
  parameter int CMD_W     = 4,
  parameter int ID_W      = 6,
  localparam int IDX_W    = $clog2(SETS),
  localparam int VPN_W    = VA_W - PAGE_BITS,
  localparam int ETAG_W   = VPN_W - IDX_W,
  localparam int PPN_W    = PA_W - PAGE_BITS
) (
  input  logic             clk,
  input  logic             rstN,
  input  vpxStrb_t         strb,
  input  logic [VA_W-1:0]  reqVaddr,
  input  logic [CMD_W-1:0] reqCmd,
  input  logic [ID_W-1:0]  reqId,
  input  logic             wrEn,
  input  logic [VPN_W-1:0] wrVpn,
  input  logic [PPN_W-1:0] wrPpn,
  output logic             s2Hit,
  output logic [PA_W-1:0]  slotPaddr,
  output logic [VA_W-1:0]  slotVa,
  output logic [CMD_W-1:0] slotCmd,
  output logic [ID_W-1:0]  slotId
);
  logic [VA_W-1:0]  s1Va, s2Va, s3Va;
  logic [CMD_W-1:0] s1Cmd, s2Cmd, s3Cmd;
  logic [ID_W-1:0]  s1Id, s2Id, s3Id;
  logic [1:0][ETAG_W-1:0] rdTag, s2Tag;
  logic [1:0][PPN_W-1:0]  rdPpn, s2Ppn;
  logic [1:0]             rdVld, s2Vld;
  logic [1:0]             hitW;
  logic [PPN_W-1:0]       s3Ppn;
  logic                   hitWay;

  vpx_ways #(.SETS(SETS), .IDX_W(IDX_W), .ETAG_W(ETAG_W), .PPN_W(PPN_W)) uWays (
    .clk(clk), .rstN(rstN),
    .rdIdx(s1Va[PAGE_BITS +: IDX_W]),
    .rdTag(rdTag), .rdPpn(rdPpn), .rdVld(rdVld),
    .wrEn(wrEn), .wrIdx(wrVpn[IDX_W-1:0]), .wrTag(wrVpn[VPN_W-1:IDX_W]), .wrPpn(wrPpn),
    .hitUpd(strb.hitUpd), .hitIdx(s2Va[PAGE_BITS +: IDX_W]), .hitWay(hitWay)
  );

  for (genvar w = 0; w < 2; w++) begin : gCmp
    assign hitW[w] = s2Vld[w] && (s2Tag[w] == s2Va[VA_W-1 -: ETAG_W]);
  end
  assign s2Hit  = |hitW;
  assign hitWay = hitW[1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      s1Va <= '0; s1Cmd <= '0; s1Id <= '0;
      s2Va <= '0; s2Cmd <= '0; s2Id <= '0;
      s2Tag <= '0; s2Ppn <= '0; s2Vld <= '0;
      s3Va <= '0; s3Cmd <= '0; s3Id <= '0; s3Ppn <= '0;
      slotPaddr <= '0; slotVa <= '0; slotCmd <= '0; slotId <= '0;
    end else if (strb.advance) begin
      s1Va <= reqVaddr; s1Cmd <= reqCmd; s1Id <= reqId;
      s2Va <= s1Va; s2Cmd <= s1Cmd; s2Id <= s1Id;
      s2Tag <= rdTag; s2Ppn <= rdPpn; s2Vld <= rdVld;
      s3Va <= s2Va; s3Cmd <= s2Cmd; s3Id <= s2Id;
      s3Ppn <= hitWay ? s2Ppn[1] : s2Ppn[0];
      slotPaddr <= {s3Ppn, s3Va[PAGE_BITS-1:0]};
      slotVa <= s3Va; slotCmd <= s3Cmd; slotId <= s3Id;
    end
  end

  // R5
  slot_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.advance |=> $stable(slotPaddr) && $stable(slotCmd) && $stable(slotId));

  // R6
  single_way_hit_chk: assert property (@(posedge clk) disable iff (!rstN)
    $countones(hitW) <= 1);
endmodule

// File: rtl/vpx_ctrl.sv
module vpx_ctrl import vpx_pkg::*; (
  input  logic     clk,
  input  logic     rstN,
  input  logic     reqValid,
  input  logic     outReady,
  input  logic     s2Hit,
  output vpxStrb_t strb,
  output logic     reqReady,
  output logic     outValid,
  output logic     excValid
);
  logic s1V, s2V, s3V, s3Hit, slotV, slotHit;
  logic adv;

  assign outValid = slotV && slotHit;
  assign excValid = slotV && !slotHit;
  assign adv      = !outValid || outReady;
  assign reqReady = adv;
  assign strb.advance = adv;
  assign strb.hitUpd  = adv && s2V && s2Hit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      s1V <= 1'b0; s2V <= 1'b0; s3V <= 1'b0;
      s3Hit <= 1'b0; slotV <= 1'b0; slotHit <= 1'b0;
    end else if (adv) begin
      s1V <= reqValid;
      s2V <= s1V;
      s3V <= s2V;
      s3Hit <= s2Hit;
      slotV <= s3V;
      slotHit <= s3Hit;
    end
  end

  // R4
  exc_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(outValid && excValid));

  // R5
  hold_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> outValid);

  // R4
  exc_one_cycle_chk: assert property (@(posedge clk) disable iff (!rstN)
    excValid && !s3V |=> !excValid);
endmodule

// File: rtl/vpage_xlate.sv
module vpage_xlate import vpx_pkg::*; #(
  parameter int VA_W      = 32,
  parameter int PA_W      = 32,
  parameter int PAGE_BITS = 12,
  parameter int SETS      = 32,
  parameter int CMD_W     = 4,
  parameter int ID_W      = 6,
  localparam int VPN_W    = VA_W - PAGE_BITS,
  localparam int PPN_W    = PA_W - PAGE_BITS
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  output logic             reqReady,
  input  logic [VA_W-1:0]  reqVaddr,
  input  logic [CMD_W-1:0] reqCmd,
  input  logic [ID_W-1:0]  reqId,
  output logic             outValid,
  input  logic             outReady,
  output logic [PA_W-1:0]  outPaddr,
  output logic [CMD_W-1:0] outCmd,
  output logic [ID_W-1:0]  outId,
  output logic             excValid,
  output logic [VA_W-1:0]  excVaddr,
  output logic [ID_W-1:0]  excId,
  input  logic             wrEn,
  input  logic [VPN_W-1:0] wrVpn,
  input  logic [PPN_W-1:0] wrPpn
);
  vpxStrb_t        strb;
  logic            s2Hit;
  logic [ID_W-1:0] slotId;

  vpx_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .outReady(outReady),
    .s2Hit(s2Hit), .strb(strb), .reqReady(reqReady),
    .outValid(outValid), .excValid(excValid)
  );

  vpx_dpath #(.VA_W(VA_W), .PA_W(PA_W), .PAGE_BITS(PAGE_BITS), .SETS(SETS),
              .CMD_W(CMD_W), .ID_W(ID_W)) uDp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .reqVaddr(reqVaddr), .reqCmd(reqCmd), .reqId(reqId),
    .wrEn(wrEn), .wrVpn(wrVpn), .wrPpn(wrPpn),
    .s2Hit(s2Hit), .slotPaddr(outPaddr), .slotVa(excVaddr),
    .slotCmd(outCmd), .slotId(slotId)
  );

  assign outId = slotId;
  assign excId = slotId;
endmodule

// File: tb/sim_vpage_xlate.sv
`timescale 1ns/1ps
module sim_vpage_xlate;
  logic clk = 1'b0;
  logic rstN;
  logic reqValid, reqReady, outValid, outReady, excValid, wrEn;
  logic [31:0] reqVaddr, outPaddr, excVaddr;
  logic [3:0]  reqCmd, outCmd;
  logic [5:0]  reqId, outId, excId;
  logic [19:0] wrVpn, wrPpn;

  always #2.5 clk = ~clk;

  vpage_xlate u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqVaddr(reqVaddr), .reqCmd(reqCmd), .reqId(reqId),
    .outValid(outValid), .outReady(outReady), .outPaddr(outPaddr),
    .outCmd(outCmd), .outId(outId), .excValid(excValid),
    .excVaddr(excVaddr), .excId(excId),
    .wrEn(wrEn), .wrVpn(wrVpn), .wrPpn(wrPpn)
  );

  int total = 0, bad = 0, cyc = 0;
  bit bpMode = 0, done = 0;

  // reference model of the array
  logic [14:0] mTag [32][2];
  logic [19:0] mPpn [32][2];
  bit          mVld [32][2];
  bit          mPlru [32];

  // expected results, in acceptance order
  bit          eHit [1024];
  logic [31:0] ePa [1024];
  logic [31:0] eVa [1024];
  logic [3:0]  eCmd [1024];
  logic [5:0]  eId [1024];
  int          eCyc [1024];
  bit          eLat [1024];
  string       eReq [1024];
  int wp = 0, rp = 0;

  logic [31:0] curVa; logic [3:0] curCmd; logic [5:0] curId; string curReq;
  bit lastAcc;
  bit wrFlag = 0; logic [19:0] curWrVpn, curWrPpn;
  bit pOutV = 0, pRdy = 1;
  logic [31:0] pPa; logic [3:0] pCmd; logic [5:0] pId;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic void modelWrite(input logic [19:0] vpn, input logic [19:0] ppn);
    int idx; logic [14:0] tg; int way;
    idx = int'(vpn[4:0]); tg = vpn[19:5];
    if (mVld[idx][0] && mTag[idx][0] == tg) way = 0;
    else if (mVld[idx][1] && mTag[idx][1] == tg) way = 1;
    else if (!mVld[idx][0]) way = 0;
    else if (!mVld[idx][1]) way = 1;
    else way = int'(mPlru[idx]);
    mTag[idx][way] = tg; mPpn[idx][way] = ppn; mVld[idx][way] = 1;
    mPlru[idx] = (way == 0);
  endfunction

  function automatic void modelPush();
    int idx; logic [14:0] tg;
    idx = int'(curVa[16:12]); tg = curVa[31:17];
    eHit[wp] = 0; ePa[wp] = '0;
    for (int w = 0; w < 2; w++) begin
      if (mVld[idx][w] && mTag[idx][w] == tg) begin
        eHit[wp] = 1; ePa[wp] = {mPpn[idx][w], curVa[11:0]};
        mPlru[idx] = (w == 0);
      end
    end
    eVa[wp] = curVa; eCmd[wp] = curCmd; eId[wp] = curId;
    eCyc[wp] = cyc; eLat[wp] = !bpMode; eReq[wp] = curReq;
    wp++;
  endfunction

  task automatic tick(input bit haveReq);
    bit nRdy, expR;
    @(negedge clk); cyc++;
    // R5 held output unchanged
    if (pOutV && !pRdy)
      check(outValid && outPaddr == pPa && outCmd == pCmd && outId == pId,
            "R5", "held output", {outValid, outPaddr}, {1'b1, pPa});
    nRdy = bpMode ? ((cyc % 3) != 1 && (cyc % 7) != 0) : 1'b1;
    if (excValid) begin
      if (rp >= wp) check(0, "R4", "unexpected exception", excVaddr, 0);
      else begin
        check(!eHit[rp], eReq[rp], "exception where hit expected", 1, 0);
        check(excVaddr == eVa[rp] && excId == eId[rp], eReq[rp], "exception va/id",
              {excId, excVaddr}, {eId[rp], eVa[rp]});
        if (eLat[rp]) check(cyc - eCyc[rp] == 4, "R3", "exception latency", cyc - eCyc[rp], 4);
        rp++;
      end
    end
    if (outValid && nRdy) begin
      if (rp >= wp) check(0, "R5", "unexpected output", outPaddr, 0);
      else begin
        check(eHit[rp], eReq[rp], "hit where miss expected", 0, 1);
        check(outPaddr == ePa[rp], eReq[rp], "physical address", outPaddr, ePa[rp]);
        check(outCmd == eCmd[rp] && outId == eId[rp], "R2", "cmd/id passthrough",
              {outCmd, outId}, {eCmd[rp], eId[rp]});
        if (eLat[rp]) check(cyc - eCyc[rp] == 4, "R3", "output latency", cyc - eCyc[rp], 4);
        rp++;
      end
    end
    pOutV = outValid; pRdy = nRdy; pPa = outPaddr; pCmd = outCmd; pId = outId;
    outReady = nRdy;
    reqValid = haveReq; reqVaddr = curVa; reqCmd = curCmd; reqId = curId;
    wrEn = wrFlag; wrVpn = curWrVpn; wrPpn = curWrPpn;
    #1;
    expR = !outValid || nRdy;
    check(reqReady == expR, "R9", "reqReady", reqReady, expR);
    lastAcc = haveReq && expR;
    if (lastAcc) modelPush();
  endtask

  task automatic send(input logic [31:0] va, input logic [3:0] cmd,
                      input logic [5:0] id, input string req);
    curVa = va; curCmd = cmd; curId = id; curReq = req;
    lastAcc = 0;
    while (!lastAcc) tick(1);
  endtask

  task automatic drain();
    int guard = 0;
    while (rp < wp && guard < 200) begin tick(0); guard++; end
    check(rp == wp, "R5", "all results delivered", rp, wp);
    tick(0); tick(0);
  endtask

  task automatic doWrite(input logic [19:0] vpn, input logic [19:0] ppn);
    drain();
    curWrVpn = vpn; curWrPpn = ppn; wrFlag = 1;
    tick(0);
    wrFlag = 0;
    modelWrite(vpn, ppn);
  endtask

  function automatic logic [14:0] tagA(input int s); return 15'(s * 3 + 1); endfunction
  function automatic logic [14:0] tagB(input int s); return 15'(s * 7 + 200); endfunction

  task automatic sweep(input string req);
    for (int s = 0; s < 32; s++) begin
      send({tagA(s), 5'(s), 12'(s * 37)}, 4'(s), 6'(s), req);
      send({tagB(s), 5'(s), 12'(4095 - s)}, 4'(s + 3), 6'(s + 32), req);
      send({tagA(s) ^ 15'h4000, 5'(s), 12'(s)}, 4'(s), 6'(s ^ 5), "R4");
      send({tagA(s), 5'((s + 1) % 32), 12'h0a5}, 4'(s), 6'(s ^ 9), "R6");
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired actual=%0d expected=done", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [14:0] t7a, t7b;
    for (int s = 0; s < 32; s++) begin
      mPlru[s] = 0;
      for (int w = 0; w < 2; w++) begin mVld[s][w] = 0; mTag[s][w] = '0; mPpn[s][w] = '0; end
    end
    rstN = 0; reqValid = 0; outReady = 1; wrEn = 0;
    reqVaddr = '0; reqCmd = '0; reqId = '0; wrVpn = '0; wrPpn = '0;
    curVa = '0; curCmd = '0; curId = '0; curReq = "R1"; curWrVpn = '0; curWrPpn = '0;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1 reset state
    check(!outValid && !excValid && reqReady, "R1", "reset outputs",
          {outValid, excValid, reqReady}, 3'b001);

    // R1: empty array misses everywhere
    for (int i = 0; i < 4; i++) send({15'(i * 9), 5'(i * 7), 12'(i)}, 4'(i), 6'(i), "R1");
    drain();

    // R7 fill both ways of every set
    for (int s = 0; s < 32; s++) begin
      doWrite({tagA(s), 5'(s)}, 20'(s * 1000 + 5));
      doWrite({tagB(s), 5'(s)}, 20'(s * 1000 + 777));
    end

    // R2/R3 streaming, R6 index/tag split
    bpMode = 0; sweep("R2");
    drain();
    // R5 back-pressure
    bpMode = 1; sweep("R5");
    drain();
    bpMode = 0;

    // R7 rewrite of an existing page stays in its way
    doWrite({tagA(3), 5'd3}, 20'habcde);
    send({tagA(3), 5'd3, 12'h123}, 4'd1, 6'd1, "R7");
    send({tagB(3), 5'd3, 12'h456}, 4'd2, 6'd2, "R7");
    drain();

    // R8 hit steers the victim to the other way
    t7a = tagA(7); t7b = tagB(7);
    send({t7a, 5'd7, 12'h010}, 4'd3, 6'd3, "R8");
    doWrite({15'h1234, 5'd7}, 20'h11111);
    send({t7a, 5'd7, 12'h020}, 4'd4, 6'd4, "R8");
    send({t7b, 5'd7, 12'h030}, 4'd5, 6'd5, "R8");
    send({15'h1234, 5'd7, 12'h040}, 4'd6, 6'd6, "R8");
    drain();
    send({15'h1234, 5'd7, 12'h050}, 4'd7, 6'd7, "R8");
    doWrite({15'h2345, 5'd7}, 20'h22222);
    send({t7a, 5'd7, 12'h060}, 4'd8, 6'd8, "R8");
    send({15'h1234, 5'd7, 12'h070}, 4'd9, 6'd9, "R8");
    send({15'h2345, 5'd7, 12'h080}, 4'd10, 6'd10, "R8");
    drain();

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule